// File: doc/BRIEF.md
# Guarded Stack Control Register Access Checker

This block holds two small control registers for a guarded return-address stack: one owned by privilege level 2 and its sibling for level 1. Each request carries a decoded system-register selector, a read/write flag and write data. Alongside it comes the context of the requester: current privilege level, whether level 2 is enabled and level 3 exists, debug-halt and secure-debug-off bits, the level-3 stack-enable bit, hypervisor host-alias and nested-virtualisation bits, and fine-grained trap permissions. In the same cycle the block returns exactly one outcome: undefined, trap to level 2, trap to level 3, register access, or redirect to memory.

The decision follows a strict priority chain rather than a plain address decode. On a register access the block names which of the two registers was reached. A read returns that register's value in the same cycle, and a write updates it on the next clock edge. Traps carry their exception class and a memory redirect carries its byte offset. Exception entry and the memory access itself belong to the surrounding logic.

Top module: `gstk_ctl_access`

## Requirements
- R1: Each register keeps only bits 9, 8, 6, 5 and 0 (write mask 0x361). All other bits read as zero whatever was written, and both registers reset to zero.
- R2: The level-2 register is selected by op0=3, op1=4, CRn=2, CRm=5, op2=0, and the level-1 register by the same values with op1=0. With no valid request, or with any other selector, `acc_kind` is zero. Otherwise exactly one bit is set: bit 0 undefined, bit 1 trap to level 2, bit 2 trap to level 3, bit 3 register access, bit 4 memory redirect.
- R3: Any access from level 0 is undefined.
- R4: At level 1, an access by the level-2 name traps to level 2 when level 2 is enabled and the nested-trap bit is 1. Otherwise it is undefined.
- R5: At level 2, and at level 1 using the level-1 name, an access traps to level 3 when level 3 exists and its stack-enable bit is 0. If the core is halted with secure debug off, the access is undefined instead.
- R6: `trap_class` is 0x18 on either trap outcome and 0 otherwise.
- R7: At level 2, an access by the level-1 name reaches the level-2 register when host-alias is 1, and the level-1 register otherwise (`acc_tgt_l2` reports which).
- R8: At level 1, a level-1-name access that was not trapped is redirected to memory when level 2 is enabled and all three nested bits are 1. `redir_off` is then 0x8D0, and 0 otherwise.
- R9: At level 1, a level-1-name access traps to level 2 when fine-grained traps are active and the permission bit for its direction (read or write) is 0. This is checked before the level-3 trap.
- R10: Level-3 accesses always reach the named register.
- R11: A register changes only on a write that resolves to register access. `rd_data` shows the reached register on a register-access read and is zero otherwise.
- R12: When `sdd_undef_first` is 1, the halted, secure-debug-off, stack-disabled case is undefined before the fine-grained trap check at level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op0 | input | 2 | Selector op0 |
| req_op1 | input | 3 | Selector op1 |
| req_crn | input | 4 | Selector CRn |
| req_crm | input | 4 | Selector CRm |
| req_op2 | input | 3 | Selector op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| lvl2_present | input | 1 | Level 2 enabled |
| lvl3_present | input | 1 | Level 3 exists |
| cpu_halted | input | 1 | Core in debug halt |
| sec_dbg_off | input | 1 | Secure debug disabled |
| lvl3_stk_en | input | 1 | Level-3 stack enable |
| host_alias | input | 1 | Hypervisor host alias of level-1 names |
| hv_nest_trap | input | 1 | Nested virtualisation trap bit |
| hv_nest_alt | input | 1 | Nested virtualisation second bit |
| hv_nest_mem | input | 1 | Nested virtualisation memory bit |
| fgt_active | input | 1 | Fine-grained traps in force |
| fgt_rd_allow | input | 1 | Fine-grained read permission (0 traps) |
| fgt_wr_allow | input | 1 | Fine-grained write permission (0 traps) |
| sdd_undef_first | input | 1 | Undefined before fine-grained check |
| acc_kind | output | 5 | One-hot outcome |
| acc_tgt_l2 | output | 1 | Register reached is the level-2 one |
| trap_class | output | 6 | Exception class on trap |
| redir_off | output | 12 | Memory offset on redirect |
| rd_data | output | 64 | Read data |

## Verification
Assertions check on every cycle that at most one outcome bit is set and that level 0 always yields undefined. They also check that level 3 always reaches the named register, that reserved bits never hold a one, and that the registers stay unchanged in any cycle without a register-access write. The ordering of the priority chain can only be shown by the bench's scenarios. These cover fine-grained trap before level-3 trap, the implementation choice that moves the debug-undefined case forward, host-alias retargeting and the nested memory redirect. The bench also shows that refused and redirected writes leave the register untouched, by reading it back from level 3.

// File: rtl/gstk_ctl_pkg.sv
package gstk_ctl_pkg;

    typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sreg_sel_t;

    localparam sreg_sel_t SEL_STK_L2 = sreg_sel_t'({2'b11, 3'b100, 4'b0010, 4'b0101, 3'b000});
    localparam sreg_sel_t SEL_STK_L1 = sreg_sel_t'({2'b11, 3'b000, 4'b0010, 4'b0101, 3'b000});

    // outcome bit positions
    localparam int OC_UNDEF = 0;
    localparam int OC_TRAP2 = 1;
    localparam int OC_TRAP3 = 2;
    localparam int OC_REG   = 3;
    localparam int OC_MEM   = 4;
    localparam int OC_W     = 5;
    typedef logic [OC_W-1:0] outcome_t;

    localparam logic [5:0]  TRAP_CLASS = 6'h18;
    localparam logic [11:0] REDIR_OFF  = 12'h8D0;

    // writable field positions: store-enable 9, push-enable 8, lock 6, return check 5, call-return select 0
    localparam int unsigned FLD_STR  = 9;
    localparam int unsigned FLD_PUSH = 8;
    localparam int unsigned FLD_LOCK = 6;
    localparam int unsigned FLD_RCHK = 5;
    localparam int unsigned FLD_CRS  = 0;

    function automatic logic [63:0] wr_mask();
        logic [63:0] m;
        m = '0;
        m[FLD_STR]  = 1'b1;
        m[FLD_PUSH] = 1'b1;
        m[FLD_LOCK] = 1'b1;
        m[FLD_RCHK] = 1'b1;
        m[FLD_CRS]  = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        lvl_e lvl;
        logic l2_on;
        logic l3_here;
        logic halted;
        logic sdd;
        logic stk_en;
        logic alias_on;
        logic nv_trap;
        logic nv_alt;
        logic nv_mem;
        logic fgt_on;
        logic fgt_rd_ok;
        logic fgt_wr_ok;
        logic sdd_first;
    } req_ctx_t;

endpackage

// File: rtl/gstk_sel_decode.sv
module gstk_sel_decode
    import gstk_ctl_pkg::*;
(
    input  sreg_sel_t sel,
    output logic      hit_l2,
    output logic      hit_l1
);
    assign hit_l2 = (sel == SEL_STK_L2);
    assign hit_l1 = (sel == SEL_STK_L1);
endmodule

// File: rtl/gstk_access_arbiter.sv
module gstk_access_arbiter
    import gstk_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  logic     hit_l2,
    input  logic     hit_l1,
    input  logic     write,
    input  req_ctx_t ctx,
    output outcome_t outcome,
    output logic     tgt_l2
);
    logic stk_off, dbg_lock, early_undef, fgt_trap, nested_mem;

    assign stk_off     = ctx.l3_here && !ctx.stk_en;
    assign dbg_lock    = ctx.halted && ctx.sdd;
    assign early_undef = stk_off && dbg_lock && ctx.sdd_first;
    assign fgt_trap    = ctx.l2_on && ctx.fgt_on && !(write ? ctx.fgt_wr_ok : ctx.fgt_rd_ok);
    assign nested_mem  = ctx.l2_on && ctx.nv_trap && ctx.nv_alt && ctx.nv_mem;

    always_comb begin
        outcome = '0;
        tgt_l2  = 1'b0;
        if (valid && (hit_l2 || hit_l1)) begin
            unique case (ctx.lvl)
                LVL0: outcome[OC_UNDEF] = 1'b1;
                LVL1: begin
                    if (hit_l2) begin
                        if (ctx.l2_on && ctx.nv_trap) outcome[OC_TRAP2] = 1'b1;
                        else                          outcome[OC_UNDEF] = 1'b1;
                    end else if (early_undef) begin
                        outcome[OC_UNDEF] = 1'b1;
                    end else if (fgt_trap) begin
                        outcome[OC_TRAP2] = 1'b1;
                    end else if (stk_off) begin
                        if (dbg_lock) outcome[OC_UNDEF] = 1'b1;
                        else          outcome[OC_TRAP3] = 1'b1;
                    end else if (nested_mem) begin
                        outcome[OC_MEM] = 1'b1;
                    end else begin
                        outcome[OC_REG] = 1'b1;
                    end
                end
                LVL2: begin
                    if (early_undef) begin
                        outcome[OC_UNDEF] = 1'b1;
                    end else if (stk_off) begin
                        if (dbg_lock) outcome[OC_UNDEF] = 1'b1;
                        else          outcome[OC_TRAP3] = 1'b1;
                    end else begin
                        outcome[OC_REG] = 1'b1;
                        tgt_l2 = hit_l2 || ctx.alias_on;
                    end
                end
                LVL3: begin
                    outcome[OC_REG] = 1'b1;
                    tgt_l2 = hit_l2;
                end
                default: outcome = '0;
            endcase
        end
    end

    // R2: never more than one outcome
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(outcome));

    // R3: level 0 never gets through
    assert_lvl0_undef_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && (hit_l2 || hit_l1) && ctx.lvl == LVL0) |-> (outcome == outcome_t'(1) << OC_UNDEF));

    // R10: level 3 reaches the register it names
    assert_lvl3_direct_R10: assert property (@(posedge clk) disable iff (rst)
        (valid && (hit_l2 || hit_l1) && ctx.lvl == LVL3) |-> (outcome[OC_REG] && tgt_l2 == hit_l2));
endmodule

// File: rtl/gstk_ctl_regfile.sv
module gstk_ctl_regfile #(
    parameter int DATA_W = 64,
    parameter int NREG   = 2,
    parameter logic [DATA_W-1:0] MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int IDX_W = $clog2(NREG);

    logic [NREG-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                regs[g] <= wr_data & MASK;
            end
        end

        // R1: reserved bits stay clear
        assert_res0_R1: assert property (@(posedge clk) disable iff (rst)
            (regs[g] & ~MASK) == '0);
    end

    assign rd_data = regs[rd_idx];

    // R11: no write, no change
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));
endmodule

// File: rtl/gstk_ctl_access.sv
module gstk_ctl_access
    import gstk_ctl_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cur_lvl,
    input  logic              lvl2_present,
    input  logic              lvl3_present,
    input  logic              cpu_halted,
    input  logic              sec_dbg_off,
    input  logic              lvl3_stk_en,
    input  logic              host_alias,
    input  logic              hv_nest_trap,
    input  logic              hv_nest_alt,
    input  logic              hv_nest_mem,
    input  logic              fgt_active,
    input  logic              fgt_rd_allow,
    input  logic              fgt_wr_allow,
    input  logic              sdd_undef_first,
    output logic [OC_W-1:0]   acc_kind,
    output logic              acc_tgt_l2,
    output logic [5:0]        trap_class,
    output logic [11:0]       redir_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREG = 2;
    localparam logic [DATA_W-1:0] MASK = DATA_W'(wr_mask());

    sreg_sel_t sel;
    req_ctx_t  ctx;
    logic      hit_l2, hit_l1, tgt_l2;
    outcome_t  oc;
    logic [DATA_W-1:0] rf_rd;

    assign sel = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
    assign ctx = '{lvl: lvl_e'(cur_lvl), l2_on: lvl2_present, l3_here: lvl3_present,
                   halted: cpu_halted, sdd: sec_dbg_off, stk_en: lvl3_stk_en,
                   alias_on: host_alias, nv_trap: hv_nest_trap, nv_alt: hv_nest_alt,
                   nv_mem: hv_nest_mem, fgt_on: fgt_active, fgt_rd_ok: fgt_rd_allow,
                   fgt_wr_ok: fgt_wr_allow, sdd_first: sdd_undef_first};

    gstk_sel_decode u_dec (
        .sel    (sel),
        .hit_l2 (hit_l2),
        .hit_l1 (hit_l1)
    );

    gstk_access_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .valid   (req_valid),
        .hit_l2  (hit_l2),
        .hit_l1  (hit_l1),
        .write   (req_write),
        .ctx     (ctx),
        .outcome (oc),
        .tgt_l2  (tgt_l2)
    );

    gstk_ctl_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .MASK   (MASK)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (oc[OC_REG] && req_write),
        .wr_idx  (tgt_l2),
        .wr_data (req_wdata),
        .rd_idx  (tgt_l2),
        .rd_data (rf_rd)
    );

    assign acc_kind   = oc;
    assign acc_tgt_l2 = tgt_l2;
    assign trap_class = (oc[OC_TRAP2] || oc[OC_TRAP3]) ? TRAP_CLASS : 6'h0;
    assign redir_off  = oc[OC_MEM] ? REDIR_OFF : 12'h0;
    assign rd_data    = (oc[OC_REG] && !req_write) ? rf_rd : '0;
endmodule

// File: tb/tb_gstk_ctl_access.sv
module tb_gstk_ctl_access;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_op0 = 0;
    logic [2:0]  req_op1 = 0, req_op2 = 0;
    logic [3:0]  req_crn = 0, req_crm = 0;
    logic [63:0] req_wdata = 0;
    logic [1:0]  cur_lvl = 0;
    logic lvl2_present = 0, lvl3_present = 0, cpu_halted = 0, sec_dbg_off = 0, lvl3_stk_en = 0;
    logic host_alias = 0, hv_nest_trap = 0, hv_nest_alt = 0, hv_nest_mem = 0;
    logic fgt_active = 0, fgt_rd_allow = 0, fgt_wr_allow = 0, sdd_undef_first = 0;
    logic [4:0]  acc_kind;
    logic        acc_tgt_l2;
    logic [5:0]  trap_class;
    logic [11:0] redir_off;
    logic [63:0] rd_data;

    gstk_ctl_access dut (.*);

    // staged context, copied onto the pins by the driver
    logic [1:0] s_lvl = 2'd3;
    logic s_l2p = 1, s_l3p = 1, s_halt = 0, s_sdd = 0, s_stk = 1, s_alias = 0;
    logic s_nv = 0, s_nv1 = 0, s_nv2 = 0, s_fgt = 0, s_rda = 1, s_wra = 1, s_first = 0;

    localparam logic [4:0] K_U = 5'd1, K_T2 = 5'd2, K_T3 = 5'd4, K_RG = 5'd8, K_MM = 5'd16;

    typedef struct {
        logic [4:0]  kind;
        logic        tgt;
        logic [63:0] rd;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0;
    bit done = 0;

    // sel: 0 level-2 name, 1 level-1 name, 2 other selector, 3 no request
    task automatic req(input int sel, input bit wr, input logic [63:0] wd,
                       input logic [4:0] kind, input bit tgt, input logic [63:0] rd, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        cur_lvl = s_lvl; lvl2_present = s_l2p; lvl3_present = s_l3p; cpu_halted = s_halt;
        sec_dbg_off = s_sdd; lvl3_stk_en = s_stk; host_alias = s_alias; hv_nest_trap = s_nv;
        hv_nest_alt = s_nv1; hv_nest_mem = s_nv2; fgt_active = s_fgt; fgt_rd_allow = s_rda;
        fgt_wr_allow = s_wra; sdd_undef_first = s_first;
        req_valid = (sel != 3);
        req_op0 = 2'b11; req_crn = 4'b0010; req_crm = 4'b0101; req_op2 = 3'b000;
        req_op1 = (sel == 0) ? 3'b100 : (sel == 1) ? 3'b000 : 3'b001;
        req_write = wr; req_wdata = wd;
        e.kind = kind; e.tgt = tgt; e.rd = rd; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: compare in the middle of the cycle
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(acc_kind == e.kind, e.tag, "kind", 64'(acc_kind), 64'(e.kind));
                chk(trap_class == ((e.kind == K_T2 || e.kind == K_T3) ? 6'h18 : 6'h0), "R6", "class",
                    64'(trap_class), (e.kind == K_T2 || e.kind == K_T3) ? 64'h18 : 64'h0);
                chk(redir_off == ((e.kind == K_MM) ? 12'h8D0 : 12'h0), "R8", "offset",
                    64'(redir_off), (e.kind == K_MM) ? 64'h8D0 : 64'h0);
                if (e.kind == K_RG)
                    chk(acc_tgt_l2 == e.tgt, e.tag, "target", 64'(acc_tgt_l2), 64'(e.tgt));
                chk(rd_data == e.rd, e.tag, "rdata", rd_data, e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        req(3, 0, 0, 5'd0, 0, 0, "R2");                     // idle
        req(0, 0, 0, K_RG, 1, 0, "R1");                     // reset value level-2
        req(1, 0, 0, K_RG, 0, 0, "R1");                     // reset value level-1
        req(2, 0, 0, 5'd0, 0, 0, "R2");                     // foreign selector
        req(0, 1, '1, K_RG, 1, 0, "R10");
        req(0, 0, 0, K_RG, 1, 64'h361, "R1");
        req(1, 1, 64'hFFFF_FFFF_FFFF_FC9E, K_RG, 0, 0, "R1");
        req(1, 0, 0, K_RG, 0, 0, "R1");
        req(1, 1, 64'h121, K_RG, 0, 0, "R11");
        s_lvl = 0;
        req(0, 0, 0, K_U, 0, 0, "R3");
        req(1, 1, 0, K_U, 0, 0, "R3");
        s_lvl = 3;
        req(1, 0, 0, K_RG, 0, 64'h121, "R11");
        // level 1, level-2 name
        s_lvl = 1; s_nv = 1;
        req(0, 0, 0, K_T2, 0, 0, "R4");
        s_nv = 0;
        req(0, 1, 0, K_U, 0, 0, "R4");
        s_l2p = 0; s_nv = 1;
        req(0, 0, 0, K_U, 0, 0, "R4");
        s_l2p = 1; s_nv = 0;
        // level 2, stack disabled at level 3
        s_lvl = 2; s_stk = 0;
        req(0, 0, 0, K_T3, 0, 0, "R5");
        s_halt = 1; s_sdd = 1;
        req(1, 0, 0, K_U, 0, 0, "R5");
        s_sdd = 0;
        req(0, 1, 0, K_T3, 0, 0, "R5");
        s_halt = 0; s_stk = 1;
        // host alias
        s_alias = 1;
        req(1, 0, 0, K_RG, 1, 64'h361, "R7");
        s_alias = 0;
        req(1, 0, 0, K_RG, 0, 64'h121, "R7");
        s_alias = 1;
        req(1, 1, 64'h20, K_RG, 1, 0, "R7");
        s_lvl = 3;
        req(0, 0, 0, K_RG, 1, 64'h20, "R7");
        s_alias = 0;
        // nested memory redirect
        s_lvl = 1; s_nv = 1; s_nv1 = 1; s_nv2 = 1;
        req(1, 0, 0, K_MM, 0, 0, "R8");
        req(1, 1, 0, K_MM, 0, 0, "R11");
        s_lvl = 3;
        req(1, 0, 0, K_RG, 0, 64'h121, "R11");
        s_lvl = 1; s_nv1 = 0;
        req(1, 0, 0, K_RG, 0, 64'h121, "R8");
        s_nv = 0; s_nv2 = 0;
        // fine-grained trap ahead of level-3 trap
        s_fgt = 1; s_rda = 0; s_stk = 0;
        req(1, 0, 0, K_T2, 0, 0, "R9");
        req(1, 1, 0, K_T3, 0, 0, "R9");
        s_rda = 1;
        req(1, 0, 0, K_T3, 0, 0, "R9");
        s_rda = 0;
        // implementation choice on debug-undefined ordering
        s_halt = 1; s_sdd = 1; s_first = 1;
        req(1, 0, 0, K_U, 0, 0, "R12");
        s_first = 0;
        req(1, 0, 0, K_T2, 0, 0, "R12");
        s_halt = 0; s_sdd = 0; s_fgt = 0; s_rda = 1; s_stk = 1;
        // no level 3: stack bit ignored
        s_lvl = 2; s_l3p = 0; s_stk = 0;
        req(0, 0, 0, K_RG, 1, 64'h20, "R5");
        s_lvl = 1;
        req(1, 0, 0, K_RG, 0, 64'h121, "R5");
        s_l3p = 1;
        // level 3 with stack disabled still direct
        s_lvl = 3;
        req(0, 1, 64'h1, K_RG, 1, 0, "R10");
        s_stk = 1;
        req(0, 0, 0, K_RG, 1, 64'h1, "R10");
        req(3, 0, 0, 5'd0, 0, 0, "R2");
        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule